// File: doc/BRIEF.md
# Vertical Blanking Ancillary Packet Inserter

This block takes packets from an incoming packet stream, keeps only those whose type marks them as ancillary, and places their payload into the vertical blanking interval of an outgoing video line stream. A timing generator supplies the current line number, the field bit, a vertical blanking flag, a per-cycle slot flag (the part of a blanking line where words may be written), and a frame-start pulse. Every other packet type is taken off the input and dropped here, because other logic handles it.

One packet is held at a time. While that packet is held, the input is stalled by lowering ready. Insertion is armed when, inside vertical blanking, the line number matches the start line for the current field. Interlaced field 0 has its own start line. Every other case, progressive video or field 1, uses the main start line. Each packet goes out one word per slot: first a three-word flag (all zeros, all ones, all ones), then the payload in arrival order. When vertical blanking ends, any packet still held is thrown away and a sticky overflow flag is raised. The start lines are captured on the frame-start pulse, so a change to them made in mid-frame applies from the next frame.

Top module: `vbi_anc_inserter`

## Requirements
- R1: A packet is ancillary only if bits [3:0] of its first word (the word with `in_sop` high) equal 13. Packets of any other type are accepted and dropped, and they produce no output word.
- R2: `out_valid` is high only in the cycle after a cycle in which `tm_vblank` was high.
- R3: With `cfg_interlaced` low, or with `tm_field` high, insertion begins only once `tm_line` equals the captured main start line during vertical blanking. It stays armed until vertical blanking ends.
- R4: With `cfg_interlaced` high and `tm_field` low, the field-0 start line arms insertion instead of the main start line.
- R5: A held packet is sent as 0x000, 0x3FF, 0x3FF (for a 10-bit word), followed by its payload words in the order they arrived. The header word itself is never sent.
- R6: When `tm_vblank` falls while a packet is still held, the rest of that packet is discarded and `overflow` goes high. `overflow` then stays high until reset.
- R7: Words leave only when `tm_active` is high, at most one per clock. A low `tm_active` pauses the sequence without losing or reordering any word. Each word appears on `out_valid`/`out_data` one cycle after the cycle in which it left.
- R8: `in_ready` is low from the cycle after an ancillary packet's last word is accepted until its final word has been sent or it has been discarded.
- R9: `cfg_start_line` and `cfg_start_line_f0` take effect only when `tm_frame_start` is high.
- R10: After reset, `in_ready` is high, and both `out_valid` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input may be accepted |
| in_sop | input | 1 | First word of a packet (carries the type in [3:0]) |
| in_eop | input | 1 | Last word of a packet |
| in_data | input | DW | Input word |
| tm_line | input | LW | Current line number |
| tm_field | input | 1 | Current field (1 = field 1) |
| tm_vblank | input | 1 | Vertical blanking in progress |
| tm_active | input | 1 | A write slot is available this cycle |
| tm_frame_start | input | 1 | Frame-start pulse, captures start lines |
| cfg_interlaced | input | 1 | Video is interlaced |
| cfg_start_line | input | LW | Main start line |
| cfg_start_line_f0 | input | LW | Start line for interlaced field 0 |
| out_valid | output | 1 | Inserted word valid |
| out_data | output | DW | Inserted word |
| overflow | output | 1 | Sticky: a held packet was discarded |

## Verification
The bench uses the default 10-bit words, 11-bit line numbers and an 8-word packet buffer. Checking the flag words as 0x000/0x3FF/0x3FF and the payload values therefore needs no scaling. The bench drives the timing inputs directly, one task per scenario, rather than through a real raster, so it can set any line, field, slot pattern or blanking edge at once. This lets it reach the field-0 start line, a slot flag that toggles every cycle in the middle of a packet, a start-line write between frame-start pulses, and a blanking edge that arrives while a packet is still held.

// File: rtl/vbi_anc_inserter.sv
module vbi_anc_inserter #(
  parameter int DW       = 10,
  parameter int LW       = 11,
  parameter int DEPTH    = 8,
  parameter int ANC_TYPE = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic [DW-1:0] in_data,
  input  logic [LW-1:0] tm_line,
  input  logic          tm_field,
  input  logic          tm_vblank,
  input  logic          tm_active,
  input  logic          tm_frame_start,
  input  logic          cfg_interlaced,
  input  logic [LW-1:0] cfg_start_line,
  input  logic [LW-1:0] cfg_start_line_f0,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          overflow
);
  localparam int LENW = $clog2(DEPTH + 1);
  localparam int POSW = $clog2(DEPTH + 4);
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]   mem [DEPTH];
  logic [LENW-1:0] len_q;
  logic [POSW-1:0] pos_q;
  logic [LW-1:0]   start_q, start_f0_q;
  logic            full_q, cap_q, armed_q, vb_q;

  wire           acc    = in_valid & in_ready;
  wire           is_anc = in_data[3:0] == ANC_TYPE[3:0];
  wire [LW-1:0]  sel    = (cfg_interlaced && !tm_field) ? start_f0_q : start_q;
  wire           hit    = tm_vblank && (tm_line == sel);
  wire           emit   = full_q && tm_vblank && (armed_q || hit) && tm_active;
  wire           vb_end = vb_q && !tm_vblank;
  wire           last   = pos_q == (POSW'(len_q) + POSW'(2));
  wire [IW-1:0]  rd_idx = IW'(pos_q - POSW'(3));
  wire [DW-1:0]  word   = (pos_q == '0) ? '0 : (pos_q < POSW'(3)) ? '1 : mem[rd_idx];

  assign in_ready = !full_q;

  always_ff @(posedge clk)
    if (acc && cap_q && !in_sop && len_q < LENW'(DEPTH))
      mem[len_q[IW-1:0]] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q     <= 1'b0;
      cap_q      <= 1'b0;
      len_q      <= '0;
      pos_q      <= '0;
      armed_q    <= 1'b0;
      vb_q       <= 1'b0;
      overflow   <= 1'b0;
      start_q    <= '0;
      start_f0_q <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
    end else begin
      vb_q      <= tm_vblank;
      armed_q   <= tm_vblank && (armed_q || hit);
      out_valid <= emit;
      if (emit) out_data <= word;
      if (tm_frame_start) begin
        start_q    <= cfg_start_line;
        start_f0_q <= cfg_start_line_f0;
      end
      if (vb_end && full_q) begin
        full_q   <= 1'b0;
        pos_q    <= '0;
        overflow <= 1'b1;
      end else if (emit) begin
        pos_q <= last ? '0 : pos_q + POSW'(1);
        if (last) full_q <= 1'b0;
      end
      if (acc) begin
        if (in_sop) begin
          len_q <= '0;
          cap_q <= is_anc && !in_eop;
          if (is_anc && in_eop) full_q <= 1'b1;
        end else if (cap_q) begin
          if (len_q < LENW'(DEPTH)) len_q <= len_q + LENW'(1);
          if (in_eop) begin
            full_q <= 1'b1;
            cap_q  <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/vbi_anc_inserter_chk.sv
module vbi_anc_inserter_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic tm_vblank,
  input logic tm_active,
  input logic out_valid,
  input logic overflow
);
  p_out_in_vblank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(tm_vblank));
  p_out_in_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(tm_active));
  p_ready_low_sending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(!in_ready));
  p_no_overflow_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_overflow_on_vb_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(!tm_vblank));
endmodule

bind vbi_anc_inserter vbi_anc_inserter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .tm_vblank(tm_vblank),
  .tm_active(tm_active), .out_valid(out_valid), .overflow(overflow));

// File: tb/vbi_anc_inserter_bench.sv
module vbi_anc_inserter_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, in_eop = 0;
  logic [9:0] in_data = '0;
  logic [10:0] tm_line = '0;
  logic tm_field = 0, tm_vblank = 0, tm_active = 0, tm_frame_start = 0, cfg_interlaced = 0;
  logic [10:0] cfg_start_line = '0, cfg_start_line_f0 = '0;
  logic in_ready, out_valid, overflow;
  logic [9:0] out_data;

  int checks = 0, fails = 0, obs_n = 0;
  logic [9:0] obs [256];

  always #5 clk = ~clk;

  vbi_anc_inserter u_vbi_anc_inserter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data), .tm_line(tm_line),
    .tm_field(tm_field), .tm_vblank(tm_vblank), .tm_active(tm_active),
    .tm_frame_start(tm_frame_start), .cfg_interlaced(cfg_interlaced),
    .cfg_start_line(cfg_start_line), .cfg_start_line_f0(cfg_start_line_f0),
    .out_valid(out_valid), .out_data(out_data), .overflow(overflow));

  always @(negedge clk) if (rst_n && out_valid) begin
    obs[obs_n % 256] = out_data;
    obs_n = obs_n + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic beat(input logic sop, input logic eop, input logic [9:0] d);
    in_valid = 1; in_sop = sop; in_eop = eop; in_data = d;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic send_pkt(input int typ, input int n, input int base);
    beat(1'b1, n == 0, 10'(typ));
    for (int i = 0; i < n; i++) beat(1'b0, i == n - 1, 10'(base + i));
  endtask

  task automatic frame(input int main_l, input int f0_l);
    cfg_start_line = 11'(main_l); cfg_start_line_f0 = 11'(f0_l);
    tm_frame_start = 1; cyc(1); tm_frame_start = 0;
  endtask

  task automatic leave_vb();
    tm_vblank = 0; tm_active = 0; cyc(2);
  endtask

  task automatic expect_pkt(input int start, input int n, input int base, input string req);
    chk(obs_n - start == n + 3, req, obs_n - start, n + 3);
    if (obs_n - start == n + 3) begin
      chk(obs[start % 256] == 10'h000, req, int'(obs[start % 256]), 0);
      chk(obs[(start + 1) % 256] == 10'h3FF && obs[(start + 2) % 256] == 10'h3FF,
          req, int'(obs[(start + 2) % 256]), 1023);
      for (int i = 0; i < n; i++)
        chk(obs[(start + 3 + i) % 256] == 10'(base + i), req,
            int'(obs[(start + 3 + i) % 256]), base + i);
    end
  endtask

  task automatic t_reset();
    chk(in_ready == 1, "R10 ready", int'(in_ready), 1);
    chk(out_valid == 0, "R10 out_valid", int'(out_valid), 0);
    chk(overflow == 0, "R10 overflow", int'(overflow), 0);
  endtask

  task automatic t_filter();
    int s = obs_n;
    frame(20, 30);
    tm_vblank = 1; tm_line = 20; tm_active = 1;
    send_pkt(5, 3, 10'h050);
    cyc(8);
    chk(obs_n == s, "R1 non-anc dropped", obs_n - s, 0);
    chk(in_ready == 1, "R1 ready after non-anc", int'(in_ready), 1);
    leave_vb();
  endtask

  task automatic t_vblank_gate();
    int s = obs_n;
    tm_line = 20; tm_active = 1;
    send_pkt(13, 2, 10'h0A0);
    cyc(6);
    chk(obs_n == s, "R2 no output outside vblank", obs_n - s, 0);
    tm_vblank = 1; cyc(10);
    expect_pkt(s, 2, 10'h0A0, "R2 output in vblank");
    leave_vb();
  endtask

  task automatic t_basic();
    int s = obs_n;
    tm_vblank = 1; tm_line = 10; tm_active = 1;
    send_pkt(13, 4, 10'h101);
    cyc(8);
    chk(obs_n == s, "R3 before start line", obs_n - s, 0);
    chk(in_ready == 0, "R8 ready low while held", int'(in_ready), 0);
    tm_line = 20; cyc(1); tm_line = 21; cyc(12);
    expect_pkt(s, 4, 10'h101, "R5 flag and payload");
    chk(in_ready == 1, "R8 ready back after send", int'(in_ready), 1);
    leave_vb();
  endtask

  task automatic t_slots();
    int s = obs_n;
    tm_vblank = 1; tm_line = 20; tm_active = 0;
    cyc(1); tm_line = 22;
    send_pkt(13, 3, 10'h200);
    cyc(5);
    chk(obs_n == s, "R7 no slot no output", obs_n - s, 0);
    for (int i = 0; i < 24; i++) begin tm_active = i[0]; cyc(1); end
    expect_pkt(s, 3, 10'h200, "R7 paused sequence intact");
    leave_vb();
  endtask

  task automatic t_field0();
    int s = obs_n;
    cfg_interlaced = 1; tm_field = 0;
    tm_vblank = 1; tm_line = 20; tm_active = 1;
    send_pkt(13, 1, 10'h2F0);
    cyc(8);
    chk(obs_n == s, "R4 main line ignored in field 0", obs_n - s, 0);
    tm_line = 30; cyc(8);
    expect_pkt(s, 1, 10'h2F0, "R4 field-0 start line");
    leave_vb();
    s = obs_n;
    tm_field = 1; tm_vblank = 1; tm_line = 30; tm_active = 1;
    send_pkt(13, 1, 10'h2F8);
    cyc(6);
    chk(obs_n == s, "R4 field-1 ignores f0 line", obs_n - s, 0);
    tm_line = 20; cyc(8);
    expect_pkt(s, 1, 10'h2F8, "R3 field-1 main line");
    cfg_interlaced = 0; tm_field = 0;
    leave_vb();
  endtask

  task automatic t_frame_sample();
    int s = obs_n;
    cfg_start_line = 50;
    tm_vblank = 1; tm_line = 20; tm_active = 1;
    send_pkt(13, 1, 10'h111);
    cyc(8);
    expect_pkt(s, 1, 10'h111, "R9 old line until frame start");
    leave_vb();
    frame(50, 30);
    s = obs_n;
    tm_vblank = 1; tm_line = 20; tm_active = 1;
    send_pkt(13, 1, 10'h122);
    cyc(8);
    chk(obs_n == s, "R9 new line after frame start", obs_n - s, 0);
    tm_line = 50; cyc(8);
    expect_pkt(s, 1, 10'h122, "R9 new line used");
    leave_vb();
  endtask

  task automatic t_cutoff();
    int s = obs_n;
    chk(overflow == 0, "R6 no overflow yet", int'(overflow), 0);
    tm_vblank = 1; tm_line = 40; tm_active = 1;
    send_pkt(13, 5, 10'h300);
    cyc(4);
    tm_vblank = 0; cyc(2);
    chk(overflow == 1, "R6 overflow set", int'(overflow), 1);
    chk(in_ready == 1, "R6 packet discarded", int'(in_ready), 1);
    tm_vblank = 1; tm_line = 50; cyc(12);
    chk(obs_n == s, "R6 discarded packet not sent", obs_n - s, 0);
    chk(overflow == 1, "R6 overflow sticky", int'(overflow), 1);
    leave_vb();
  endtask

  initial begin
    cyc(3);
    rst_n = 1; cyc(1);
    t_reset();
    t_filter();
    t_vblank_gate();
    t_basic();
    t_slots();
    t_field0();
    t_frame_sample();
    t_cutoff();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule